// File: doc/BRIEF.md
# Poisoned Packet Receive Handler

This block sits on the receive side of a PCI Express transaction layer, between the packet stream arriving from the data link side and the application interface. The stream carries one 32-bit doubleword per beat, with start and end markers and a valid/ready handshake. Every beat, poisoned or not, is passed to the application unchanged. No beat is dropped. The block inspects the first header doubleword of each packet for the error/poisoned flag.

When a poisoned header is accepted, the block raises a one-clock advisory error pulse and sets a sticky status bit. Software clears that bit by writing one to a small status port. The block also holds a stub configuration register. A configuration write that is not poisoned loads this register. A poisoned configuration write leaves the register alone. Both reads and writes to configuration space are still answered with a completion header. Completions built here always carry a cleared poisoned flag.

Top module: `ep_poison_rx`

## Requirements
- R1: `in_ready` equals `out_ready` in every cycle. While `in_valid` is high, the block copies `in_data`, `in_sop` and `in_eop` to its outputs in the same cycle, and `out_valid` follows `in_valid`. This includes beats of poisoned packets.
- R2: The poisoned flag is bit 14 of the first header doubleword (bit 6 of header byte 2). `adv_err` is high for exactly the one cycle after a start beat with that bit set is accepted (`in_valid` and `out_ready` both high). In all other cycles it is low.
- R3: `stat_poisoned` becomes 1 in the same cycle that `adv_err` pulses. It then stays at 1 until it is cleared.
- R4: A cycle with `stat_wr`=1 and `stat_wdata`=1 clears `stat_poisoned` from the next cycle on. `stat_wdata`=0 has no effect. If a clear and a new poisoned header fall in the same cycle, the set wins.
- R5: A configuration write has header byte 0 (bits 31:24) equal to 0x44 or 0x45, three header beats and its data in beat index 3. If it is not poisoned, `cfg_wr_en` pulses for one cycle after the data beat is accepted, `cfg_wr_data` shows that data, and `cfg_reg` holds it from then on.
- R6: A poisoned configuration write produces no `cfg_wr_en` pulse and leaves `cfg_reg` unchanged.
- R7: The end beat of a configuration read (byte 0 equal to 0x04 or 0x05) or of a configuration write produces a one-cycle `cpl_valid` pulse in the next cycle. For a read, `cpl_dw0` is 0x4A000001 and `cpl_data` is the current `cfg_reg`. For a write, `cpl_dw0` is 0x0A000000 and `cpl_data` is 0. `cpl_dw2` holds bits 31:8 of header beat 1 (requester ID and tag) in bits 31:8, with 0 in bits 7:0.
- R8: Bit 14 of `cpl_dw0` is 0 on every completion, including completions that answer poisoned requests.
- R9: After reset, `adv_err`, `stat_poisoned`, `cfg_wr_en` and `cpl_valid` are 0, and `cfg_reg` equals `CFG_RESET`.
- R10: Packets other than configuration reads and writes never cause `cpl_valid` or `cfg_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive beat valid |
| in_ready | output | 1 | Receive beat accepted |
| in_data | input | DATA_W | Receive beat doubleword |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| out_valid | output | 1 | Application beat valid |
| out_ready | input | 1 | Application can take a beat |
| out_data | output | DATA_W | Application beat doubleword |
| out_sop | output | 1 | Application first beat |
| out_eop | output | 1 | Application last beat |
| stat_wr | input | 1 | Status port write strobe |
| stat_wdata | input | 1 | Status write data, 1 clears |
| stat_poisoned | output | 1 | Sticky poisoned-packet status |
| adv_err | output | 1 | Advisory error pulse |
| cfg_wr_en | output | 1 | Stub register write pulse |
| cfg_wr_data | output | DATA_W | Data of the committed write |
| cfg_reg | output | DATA_W | Stub configuration register |
| cpl_valid | output | 1 | Completion header pulse |
| cpl_dw0 | output | DATA_W | Completion first doubleword |
| cpl_dw2 | output | DATA_W | Completion requester ID and tag doubleword |
| cpl_data | output | DATA_W | Completion payload for reads |

## Verification
Two actions can fall in the same cycle: a software clear of the sticky status and the acceptance of a new poisoned header. The bench forces `out_ready` high and holds the clear strobe during the start beat of a poisoned packet. It then expects the status to stay at 1 in the next cycle. A second pairing is a poisoned configuration write whose data beat is also its end beat. In that cycle the bench expects the completion pulse and no register update. Random traffic also lands clears on idle cycles and on cycles with a clean header. A bench model judges every cycle of this traffic.

// File: rtl/ep_rx_pkg.sv
package ep_rx_pkg;

    localparam int HDR_W     = 32;
    localparam int EP_BIT    = 14;
    localparam int FT_HI     = 31;
    localparam int FT_LO     = 24;
    localparam int CFG_D_IDX = 3;

    localparam logic [7:0] FT_CFGRD0 = 8'h04;
    localparam logic [7:0] FT_CFGRD1 = 8'h05;
    localparam logic [7:0] FT_CFGWR0 = 8'h44;
    localparam logic [7:0] FT_CFGWR1 = 8'h45;
    localparam logic [7:0] FT_CPL    = 8'h0A;
    localparam logic [7:0] FT_CPLD   = 8'h4A;

    typedef enum logic [1:0] {
        KIND_OTHER  = 2'd0,
        KIND_CFG_RD = 2'd1,
        KIND_CFG_WR = 2'd2
    } tlp_kind_e;

    typedef struct packed {
        tlp_kind_e kind;
        logic      poisoned;
    } hdr_info_t;

    typedef struct packed {
        logic              valid;
        logic [HDR_W-1:0]  dw0;
        logic [HDR_W-1:0]  dw2;
        logic [HDR_W-1:0]  data;
    } cpl_t;

    function automatic hdr_info_t decode_hdr(input logic [HDR_W-1:0] dw0);
        hdr_info_t info;
        logic [7:0] ft;
        ft            = dw0[FT_HI:FT_LO];
        info.poisoned = dw0[EP_BIT];
        if (ft == FT_CFGRD0 || ft == FT_CFGRD1)
            info.kind = KIND_CFG_RD;
        else if (ft == FT_CFGWR0 || ft == FT_CFGWR1)
            info.kind = KIND_CFG_WR;
        else
            info.kind = KIND_OTHER;
        return info;
    endfunction

    // Completion header word: the poisoned flag field is always left at zero.
    function automatic logic [HDR_W-1:0] build_cpl_dw0(input logic with_data);
        logic [7:0] ft;
        logic [7:0] len;
        ft  = with_data ? FT_CPLD : FT_CPL;
        len = with_data ? 8'h01 : 8'h00;
        return {ft, 8'h00, 8'h00, len};
    endfunction

endpackage

// File: rtl/ep_hdr_track.sv
module ep_hdr_track
    import ep_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              sop,
    input  logic [DATA_W-1:0] data,
    output logic [IDX_W-1:0]  cur_idx,
    output hdr_info_t         cur_info,
    output logic [23:0]       req_tag
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic [IDX_W-1:0] cnt_q;
    hdr_info_t        info_q;
    logic [23:0]      rt_q;

    assign cur_idx  = sop ? '0 : cnt_q;
    assign cur_info = sop ? decode_hdr(data[HDR_W-1:0]) : info_q;
    assign req_tag  = rt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            info_q <= '{kind: KIND_OTHER, poisoned: 1'b0};
            rt_q   <= '0;
        end else if (fire) begin
            cnt_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
            if (sop)
                info_q <= cur_info;
            if (cur_idx == IDX_W'(1))
                rt_q <= data[31:8];
        end
    end

endmodule

// File: rtl/ep_status_reg.sv
module ep_status_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic stat_o
);
    logic stat_q;

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= 1'b0;
        else if (set_i)
            stat_q <= 1'b1;
        else if (clr_i)
            stat_q <= 1'b0;
    end

    assign stat_o = stat_q;

    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_q && !clr_i) |=> stat_q);

    a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !stat_q);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> stat_q);

endmodule

// File: rtl/ep_cfg_stub.sv
module ep_cfg_stub
    import ep_rx_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                IDX_W     = 3,
    parameter logic [DATA_W-1:0] CFG_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              eop,
    input  logic [IDX_W-1:0]  cur_idx,
    input  hdr_info_t         cur_info,
    input  logic [DATA_W-1:0] data,
    input  logic [23:0]       req_tag,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] reg_o,
    output cpl_t              cpl_o
);
    logic              wr_hit;
    logic              commit;
    logic              cfg_end;
    logic              wr_en_q;
    logic [DATA_W-1:0] wr_data_q;
    logic [DATA_W-1:0] reg_q;
    cpl_t              cpl_q;

    assign wr_hit  = fire && (cur_info.kind == KIND_CFG_WR) && (cur_idx == IDX_W'(CFG_D_IDX));
    assign commit  = wr_hit && !cur_info.poisoned;
    assign cfg_end = fire && eop && (cur_info.kind != KIND_OTHER);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
            reg_q     <= CFG_RESET;
            cpl_q     <= '0;
        end else begin
            wr_en_q     <= commit;
            if (commit) begin
                wr_data_q <= data;
                reg_q     <= data;
            end
            cpl_q.valid <= cfg_end;
            if (cfg_end) begin
                cpl_q.dw0  <= build_cpl_dw0(cur_info.kind == KIND_CFG_RD);
                cpl_q.dw2  <= {req_tag, 8'h00};
                cpl_q.data <= (cur_info.kind == KIND_CFG_RD) ? reg_q : '0;
            end
        end
    end

    assign wr_en_o   = wr_en_q;
    assign wr_data_o = wr_data_q;
    assign reg_o     = reg_q;
    assign cpl_o     = cpl_q;

    a_r6_poison_blocks: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && cur_info.poisoned) |=> !wr_en_q);

    a_r6_reg_needs_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_q) |-> wr_en_q);

    a_r7_cpl_after_end: assert property (@(posedge clk) disable iff (rst)
        cpl_q.valid |-> $past(fire && eop));

endmodule

// File: rtl/ep_poison_rx.sv
module ep_poison_rx
    import ep_rx_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                IDX_W     = 3,
    parameter logic [DATA_W-1:0] CFG_RESET = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    input  logic              stat_wr,
    input  logic              stat_wdata,
    output logic              stat_poisoned,
    output logic              adv_err,
    output logic              cfg_wr_en,
    output logic [DATA_W-1:0] cfg_wr_data,
    output logic [DATA_W-1:0] cfg_reg,
    output logic              cpl_valid,
    output logic [DATA_W-1:0] cpl_dw0,
    output logic [DATA_W-1:0] cpl_dw2,
    output logic [DATA_W-1:0] cpl_data
);
    logic             fire;
    logic             hdr_bad;
    logic             adv_q;
    logic [IDX_W-1:0] cur_idx;
    hdr_info_t        cur_info;
    logic [23:0]      req_tag;
    cpl_t             cpl;

    // Every beat goes straight through; poisoning never stalls or drops.
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
    assign out_sop   = in_sop;
    assign out_eop   = in_eop;

    assign fire    = in_valid && out_ready;
    assign hdr_bad = fire && in_sop && cur_info.poisoned;

    ep_hdr_track #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .sop      (in_sop),
        .data     (in_data),
        .cur_idx  (cur_idx),
        .cur_info (cur_info),
        .req_tag  (req_tag)
    );

    ep_status_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .set_i  (hdr_bad),
        .clr_i  (stat_wr && stat_wdata),
        .stat_o (stat_poisoned)
    );

    ep_cfg_stub #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CFG_RESET(CFG_RESET)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .eop       (in_eop),
        .cur_idx   (cur_idx),
        .cur_info  (cur_info),
        .data      (in_data),
        .req_tag   (req_tag),
        .wr_en_o   (cfg_wr_en),
        .wr_data_o (cfg_wr_data),
        .reg_o     (cfg_reg),
        .cpl_o     (cpl)
    );

    always_ff @(posedge clk) begin
        if (rst)
            adv_q <= 1'b0;
        else
            adv_q <= hdr_bad;
    end

    assign adv_err   = adv_q;
    assign cpl_valid = cpl.valid;
    assign cpl_dw0   = cpl.dw0;
    assign cpl_dw2   = cpl.dw2;
    assign cpl_data  = cpl.data;

    a_r2_adv_from_header: assert property (@(posedge clk) disable iff (rst)
        adv_err |-> $past(in_valid && out_ready && in_sop && in_data[EP_BIT]));

    a_r3_status_with_pulse: assert property (@(posedge clk) disable iff (rst)
        adv_err |-> stat_poisoned);

    a_r1_ready_follows: assert property (@(posedge clk) disable iff (rst)
        in_ready == out_ready);

endmodule

// File: tb/ep_poison_rx_bench.sv
module ep_poison_rx_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] CFG_INIT   = 32'h1357_9BDF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_ready = 1'b0, stat_wr = 1'b0, stat_wdata = 1'b0;
    logic        in_ready, out_valid, out_sop, out_eop;
    logic [31:0] out_data, cfg_wr_data, cfg_reg, cpl_dw0, cpl_dw2, cpl_data;
    logic        stat_poisoned, adv_err, cfg_wr_en, cpl_valid;

    int errs = 0, checks = 0;
    bit force_rdy = 0, sw_auto = 1, last_hs = 0;

    // bench model state
    int          m_idx = 0, m_kind = 0;
    bit          m_ep = 0, m_stat = 0;
    logic [23:0] m_rt = '0;
    logic [31:0] m_reg = CFG_INIT;
    bit          e_adv, e_wr, e_cpl;
    logic [31:0] e_wrd, e_dw0, e_dw2, e_cd;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_poison_rx #(.DATA_W(32), .IDX_W(3), .CFG_RESET(CFG_INIT)) u_ep_poison_rx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .stat_poisoned(stat_poisoned), .adv_err(adv_err),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_reg(cfg_reg),
        .cpl_valid(cpl_valid), .cpl_dw0(cpl_dw0), .cpl_dw2(cpl_dw2), .cpl_data(cpl_data));

    function automatic int kind_of(input logic [7:0] ft);
        if (ft == 8'h04 || ft == 8'h05) return 1;
        if (ft == 8'h44 || ft == 8'h45) return 2;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cycle();
        bit hs;
        int idx;
        out_ready = force_rdy ? 1'b1 : ($urandom % 4 != 0);
        if (sw_auto) begin
            stat_wr    = ($urandom % 12 == 0);
            stat_wdata = $urandom % 2;
        end
        #1;
        chk(in_ready === out_ready, "R1", "in_ready", 32'(in_ready), 32'(out_ready));
        chk(out_valid === in_valid, "R1", "out_valid", 32'(out_valid), 32'(in_valid));
        if (in_valid) begin
            chk(out_data === in_data, "R1", "out_data", out_data, in_data);
            chk({out_sop, out_eop} === {in_sop, in_eop}, "R1", "markers",
                32'({out_sop, out_eop}), 32'({in_sop, in_eop}));
        end
        @(posedge clk);
        hs = in_valid && out_ready;
        last_hs = hs;
        e_adv = hs && in_sop && in_data[14];
        e_wr = 0; e_cpl = 0;
        if (hs) begin
            idx = in_sop ? 0 : m_idx;
            if (in_sop) begin
                m_kind = kind_of(in_data[31:24]);
                m_ep   = in_data[14];
            end
            if (idx == 1) m_rt = in_data[31:8];
            if (m_kind == 2 && idx == 3 && !m_ep) begin
                e_wr = 1; e_wrd = in_data;
            end
            if (in_eop && m_kind != 0) begin
                e_cpl = 1;
                e_dw0 = (m_kind == 1) ? 32'h4A00_0001 : 32'h0A00_0000;
                e_dw2 = {m_rt, 8'h00};
                e_cd  = (m_kind == 1) ? m_reg : 32'h0;
            end
            m_idx = (idx >= 7) ? 7 : idx + 1;
        end
        m_stat = e_adv || (m_stat && !(stat_wr && stat_wdata));
        if (e_wr) m_reg = e_wrd;
        @(negedge clk);
        chk(adv_err === e_adv, "R2", "adv_err", 32'(adv_err), 32'(e_adv));
        chk(stat_poisoned === m_stat, "R3_R4", "stat_poisoned", 32'(stat_poisoned), 32'(m_stat));
        chk(cfg_wr_en === e_wr, "R5_R6_R10", "cfg_wr_en", 32'(cfg_wr_en), 32'(e_wr));
        if (e_wr) chk(cfg_wr_data === e_wrd, "R5", "cfg_wr_data", cfg_wr_data, e_wrd);
        chk(cfg_reg === m_reg, "R6", "cfg_reg", cfg_reg, m_reg);
        chk(cpl_valid === e_cpl, "R7_R10", "cpl_valid", 32'(cpl_valid), 32'(e_cpl));
        if (e_cpl) begin
            chk(cpl_dw0 === e_dw0, "R7", "cpl_dw0", cpl_dw0, e_dw0);
            chk(cpl_dw0[14] === 1'b0, "R8", "cpl poisoned flag", 32'(cpl_dw0[14]), 32'h0);
            chk(cpl_dw2 === e_dw2, "R7", "cpl_dw2", cpl_dw2, e_dw2);
            chk(cpl_data === e_cd, "R7", "cpl_data", cpl_data, e_cd);
        end
    endtask

    task automatic send_pkt(input logic [7:0] ft, input bit ep, input int ndata, input bit gaps);
        logic [31:0] b [8];
        int nh, n;
        nh = ft[5] ? 4 : 3;
        n  = nh + ndata;
        b[0] = {ft, 8'h00, ep ? 8'h40 : 8'h00, 8'(ndata)};
        b[1] = {16'($urandom), 8'($urandom), 8'h0F};
        for (int i = 2; i < 8; i++) b[i] = $urandom;
        for (int i = 0; i < n; i++) begin
            in_data = b[i];
            in_sop  = (i == 0);
            in_eop  = (i == n - 1);
            do begin
                in_valid = gaps ? ($urandom % 4 != 0) : 1'b1;
                cycle();
            end while (!last_hs);
        end
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        logic [7:0] fts [8];
        logic [7:0] ft;
        void'($urandom(32'd20240611));
        fts = '{8'h40, 8'h00, 8'h20, 8'h60, 8'h04, 8'h05, 8'h44, 8'h45};
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: reset state
        chk(adv_err === 1'b0 && cfg_wr_en === 1'b0 && cpl_valid === 1'b0, "R9", "pulses",
            32'({adv_err, cfg_wr_en, cpl_valid}), 32'h0);
        chk(stat_poisoned === 1'b0, "R9", "status", 32'(stat_poisoned), 32'h0);
        chk(cfg_reg === CFG_INIT, "R9", "cfg_reg", cfg_reg, CFG_INIT);

        // directed: poisoned memory write, status clear with data 0 then 1
        force_rdy = 1; sw_auto = 0;
        send_pkt(8'h40, 1, 2, 0);
        stat_wr = 1; stat_wdata = 0; idle(1);   // R4 no effect
        stat_wr = 1; stat_wdata = 1; idle(1);   // R4 clears
        stat_wr = 0; idle(1);
        // R4: clear coincides with a new poisoned header, set wins
        stat_wr = 1; stat_wdata = 1;
        send_pkt(8'h00, 1, 0, 0);
        stat_wr = 0; idle(1);
        // R5 clean config write, R6 poisoned config write, R8 poisoned read
        send_pkt(8'h44, 0, 1, 0);
        send_pkt(8'h45, 1, 1, 0);
        send_pkt(8'h04, 1, 0, 0);
        send_pkt(8'h05, 0, 0, 0);
        // R10 non-config packets
        send_pkt(8'h60, 0, 3, 0);
        idle(2);

        // random traffic
        force_rdy = 0; sw_auto = 1;
        for (int p = 0; p < 400; p++) begin
            ft = fts[$urandom % 8];
            send_pkt(ft, ($urandom % 3 == 0), ft[6] ? ((kind_of(ft) == 2) ? 1 : 1 + $urandom % 4) : 0, 1);
            if ($urandom % 3 == 0) idle($urandom % 3);
        end
        idle(3);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule